// File: doc/BRIEF.md
# Banked Prioritized Interrupt Controller

This block gathers interrupt request lines in groups of 32, one group per bank, with the number of banks set by a parameter. Each line has its own configuration word. The word sets a 5-bit priority, chooses edge or level capture, and sends the line either to the normal output (`irq_out`) or to the fast output (`fiq_out`). Captured requests sit in a per-bank pending register. A per-bank mask register gates them before arbitration.

Each output has its own grant state machine with two states. In `GRANT_ARMED` the output is low. When at least one unmasked pending line of that output's type exists, the transition ARMED→HELD is taken. On that clock edge the winning line number is latched. In `GRANT_HELD` the output is high and the latched code does not change. A write of the matching bit of the control register takes the transition HELD→ARMED. That write also wins over a pending ARMED→HELD move in the same cycle. Software reads the latched code, and the read releases the winning line if that line is edge-captured. It then acknowledges. After that, arbitration runs again once.

The bus is a simple 32-bit register port with write and read strobes. Read data is combinational. Write effects and read side effects take place on the rising clock edge where the strobe is seen.

Top module: `icu_banked_top`

## Requirements
- R1: After reset, all pending bits are 0, all mask bits are 1, and every line configuration reads 0 (priority 0, edge capture, normal output). Both outputs are low and both latched codes are 0.
- R2: Bank n decodes at byte address n*0x100, and the low 8 address bits pick the register. Offsets with no register read 0 and ignore writes. This includes the code and control offsets (0x10, 0x14, 0x18) in any bank other than 0.
- R3: An edge-captured line becomes pending on the clock edge where its input is first seen high after being low. An input held high does not set the line again after it has been cleared.
- R4: A level-captured line is pending on every edge where its input is high, and it is cleared on the edge where its input falls. A pending-register write cannot clear it while its input is high.
- R5: A write to the pending register (offset 0x00) keeps only the pending bits whose written bit is 1, within the limit set by R4.
- R6: The mask register is at offset 0x04, and a 1 blocks the line. A masked pending line never raises an output. Clearing its mask bit raises the output on the following edge if the output is armed.
- R7: The configuration word of line i is at offset 0x1C + 4*i. Bits 6:2 hold the priority, bit 1 selects level (1) or edge (0) capture, and bit 0 sends the line to `fiq_out` (1) or to `irq_out` (0). Other bits read 0.
- R8: A line competes only for the output that its routing bit selects. The fast code is read at offset 0x14 in bank 0.
- R9: The winner is the candidate with the smallest priority value. On a tie the larger line number wins. The code is 32*bank + bit and is read at offset 0x14 (fast) or 0x10 (normal) in bank 0.
- R10: An armed output rises one edge after a candidate appears, and its code is latched on that edge. While the output is high the code holds, and no other arbitration takes place.
- R11: Writing bit 0 (normal) or bit 1 (fast) of the control register at bank-0 offset 0x18 lowers that output on the next edge and re-arms it. The control register reads 0.
- R12: Reading a code register clears the pending bit of the coded line when that line is edge-captured. A level-captured line stays pending.
- R13: A write to offset 0x9C sets only the lowest-numbered 1 bit of the written value as pending in the addressed bank. The offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8+BANK_W | Byte address: bank index above bit 7, register offset below |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; enables read side effects |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current state |
| req_in | input | 32*NUM_BANKS | Request inputs; bit 32*b+i is line i of bank b |
| irq_out | output | 1 | Normal interrupt output |
| fiq_out | output | 1 | Fast interrupt output |

## Verification
A request input seen high at edge k sets its pending bit at edge k. The output that line feeds rises at edge k+1, so the two results are two edges apart. Register writes, including mask and acknowledge, take effect at the edge where the strobe is seen. The output that depends on them moves one edge later. Read data belongs to the cycle in which the read strobe is set, and a read-triggered clear is visible only after that edge. The bench applies inputs after a falling edge and updates its reference model at the rising edge. It compares both outputs at the next falling edge and checks read data just before the rising edge that carries the read.

// File: rtl/icu_pkg.sv
`timescale 1ns/1ps
package icu_pkg;

    localparam int LINES  = 32;
    localparam int LINE_W = 5;
    localparam int PRIO_W = 5;
    localparam int DATA_W = 32;
    localparam int CFG_W  = PRIO_W + 2;

    localparam logic [7:0] OFF_PEND     = 8'h00;
    localparam logic [7:0] OFF_MASK     = 8'h04;
    localparam logic [7:0] OFF_CODE_IRQ = 8'h10;
    localparam logic [7:0] OFF_CODE_FIQ = 8'h14;
    localparam logic [7:0] OFF_CTRL     = 8'h18;
    localparam logic [7:0] OFF_LCFG0    = 8'h1C;
    localparam logic [7:0] OFF_LCFG_END = 8'h98;
    localparam logic [7:0] OFF_SWSET    = 8'h9C;

    typedef enum logic {
        GRANT_ARMED = 1'b0,
        GRANT_HELD  = 1'b1
    } grant_state_e;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_PEND,
        REG_MASK,
        REG_CODE_IRQ,
        REG_CODE_FIQ,
        REG_CTRL,
        REG_LCFG,
        REG_SWSET
    } reg_sel_e;

endpackage

// File: rtl/icu_line_bank.sv
`timescale 1ns/1ps
// One bank of 32 lines: capture, pending, mask and per-line configuration.
module icu_line_bank
    import icu_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LINES-1:0]          req,
    input  logic                      pend_wr,
    input  logic                      mask_wr,
    input  logic                      cfg_wr,
    input  logic                      swset_wr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [LINE_W-1:0]         cfg_idx,
    input  logic                      code_clr,
    input  logic [LINE_W-1:0]         code_idx,
    output logic [LINES-1:0]          pend,
    output logic [LINES-1:0]          mask,
    output logic [LINES-1:0]          fiq_sel,
    output logic [LINES*PRIO_W-1:0]   prio_flat,
    output logic [CFG_W-1:0]          cfg_rd
);

    logic [LINES-1:0]  req_q;
    logic [LINES-1:0]  pend_q;
    logic [LINES-1:0]  mask_q;
    logic [LINES-1:0]  lvl_q;
    logic [LINES-1:0]  fiq_q;
    logic [PRIO_W-1:0] prio_q [LINES];

    logic [LINES-1:0]  rise_v;
    logic [LINES-1:0]  fall_v;
    logic [LINES-1:0]  sw_v;
    logic [LINES-1:0]  set_v;
    logic [LINES-1:0]  clr_v;
    logic [LINES-1:0]  rdclr_v;
    logic [LINES-1:0]  pend_n;

    always_comb begin
        rise_v  = req & ~req_q;
        fall_v  = ~req & req_q;
        sw_v    = swset_wr ? (wdata & (~wdata + 1'b1)) : '0;
        rdclr_v = code_clr ? ((LINES'(1) << code_idx) & ~lvl_q) : '0;
        set_v   = (~lvl_q & rise_v) | (lvl_q & req) | sw_v;
        clr_v   = (pend_wr ? ~wdata : '0) | rdclr_v | (lvl_q & fall_v);
        pend_n  = (pend_q & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= '0;
            pend_q <= '0;
        end else begin
            req_q  <= req;
            pend_q <= pend_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (mask_wr) begin
            mask_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
            fiq_q <= '0;
            for (int i = 0; i < LINES; i++) begin
                prio_q[i] <= '0;
            end
        end else if (cfg_wr) begin
            prio_q[cfg_idx] <= wdata[PRIO_W+1:2];
            lvl_q[cfg_idx]  <= wdata[1];
            fiq_q[cfg_idx]  <= wdata[0];
        end
    end

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_prio
            assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
        end
    endgenerate

    assign pend    = pend_q;
    assign mask    = mask_q;
    assign fiq_sel = fiq_q;
    assign cfg_rd  = {prio_q[cfg_idx], lvl_q[cfg_idx], fiq_q[cfg_idx]};

endmodule

// File: rtl/icu_winner_pick.sv
`timescale 1ns/1ps
// Picks the candidate with the smallest priority value; larger index wins ties.
module icu_winner_pick
    import icu_pkg::*;
#(
    parameter int N_LINES = 64,
    parameter int CODE_W  = 6
) (
    input  logic [N_LINES-1:0]        cand,
    input  logic [N_LINES*PRIO_W-1:0] prio_flat,
    output logic                      any,
    output logic [CODE_W-1:0]         code
);

    logic [PRIO_W-1:0] best;

    always_comb begin
        any  = 1'b0;
        best = '1;
        code = '0;
        for (int i = 0; i < N_LINES; i++) begin
            if (cand[i] && (prio_flat[i*PRIO_W +: PRIO_W] <= best)) begin
                best = prio_flat[i*PRIO_W +: PRIO_W];
                code = CODE_W'(i);
                any  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/icu_grant_fsm.sv
`timescale 1ns/1ps
// One-shot grant: arms on acknowledge, fires once per arming.
module icu_grant_fsm
    import icu_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any,
    input  logic [CODE_W-1:0] win,
    input  logic              ack,
    output logic              grant,
    output logic [CODE_W-1:0] code_q
);

    grant_state_e state_q;
    grant_state_e state_n;
    logic         take;

    always_comb begin
        state_n = state_q;
        take    = 1'b0;
        unique case (state_q)
            GRANT_ARMED: begin
                if (!ack && any) begin
                    state_n = GRANT_HELD;
                    take    = 1'b1;
                end
            end
            GRANT_HELD: begin
                if (ack) begin
                    state_n = GRANT_ARMED;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GRANT_ARMED;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (take) begin
            code_q <= win;
        end
    end

    assign grant = (state_q == GRANT_HELD);

endmodule

// File: rtl/icu_banked_top.sv
`timescale 1ns/1ps
module icu_banked_top
    import icu_pkg::*;
#(
    parameter  int NUM_BANKS = 2,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W    = 8 + BANK_W,
    localparam int N_LINES   = NUM_BANKS * LINES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [N_LINES-1:0] req_in,
    output logic               irq_out,
    output logic               fiq_out
);

    localparam int CODE_W = $clog2(N_LINES);

    logic [7:0]        off;
    logic [BANK_W-1:0] bank_idx;
    logic [BANK_W-1:0] bsel;
    logic              bank_ok;
    logic              is_bank0;
    reg_sel_e          sel;
    logic [LINE_W-1:0] cfg_idx;
    logic [CODE_W-1:0] rd_code;
    logic              rd_code_hit;

    logic [LINES-1:0]        pend_b  [NUM_BANKS];
    logic [LINES-1:0]        mask_b  [NUM_BANKS];
    logic [CFG_W-1:0]        cfg_b   [NUM_BANKS];
    logic [N_LINES*PRIO_W-1:0] prio_all;

    logic [N_LINES-1:0] cand_k [2];
    logic               any_k  [2];
    logic [CODE_W-1:0]  win_k  [2];
    logic               ack_k  [2];
    logic               out_k  [2];
    logic [CODE_W-1:0]  code_k [2];

    logic [N_LINES-1:0] cand_irq;
    logic [N_LINES-1:0] cand_fiq;
    logic [CODE_W-1:0]  code_irq_q;
    logic [CODE_W-1:0]  code_fiq_q;

    // Address decode
    assign off      = bus_addr[7:0];
    assign bank_idx = bus_addr[ADDR_W-1:8];
    assign bank_ok  = int'(bank_idx) < NUM_BANKS;
    assign is_bank0 = bank_ok && (bank_idx == '0);
    assign bsel     = bank_ok ? bank_idx : '0;
    assign cfg_idx  = LINE_W'((off - OFF_LCFG0) >> 2);

    always_comb begin
        sel = REG_NONE;
        if (bank_ok) begin
            if (off == OFF_PEND) begin
                sel = REG_PEND;
            end else if (off == OFF_MASK) begin
                sel = REG_MASK;
            end else if (off == OFF_CODE_IRQ && is_bank0) begin
                sel = REG_CODE_IRQ;
            end else if (off == OFF_CODE_FIQ && is_bank0) begin
                sel = REG_CODE_FIQ;
            end else if (off == OFF_CTRL && is_bank0) begin
                sel = REG_CTRL;
            end else if (off == OFF_SWSET) begin
                sel = REG_SWSET;
            end else if (off >= OFF_LCFG0 && off <= OFF_LCFG_END && off[1:0] == 2'b00) begin
                sel = REG_LCFG;
            end
        end
    end

    assign rd_code_hit = bus_rd && (sel == REG_CODE_IRQ || sel == REG_CODE_FIQ);
    assign rd_code     = (sel == REG_CODE_FIQ) ? code_fiq_q : code_irq_q;

    // Banks
    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic             hit;
            logic             clr_here;
            logic [LINES-1:0] fiq_b;
            assign hit      = bank_ok && (int'(bank_idx) == b);
            assign clr_here = rd_code_hit && (int'(rd_code >> LINE_W) == b);

            icu_line_bank u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .req       (req_in[b*LINES +: LINES]),
                .pend_wr   (bus_wr && hit && sel == REG_PEND),
                .mask_wr   (bus_wr && hit && sel == REG_MASK),
                .cfg_wr    (bus_wr && hit && sel == REG_LCFG),
                .swset_wr  (bus_wr && hit && sel == REG_SWSET),
                .wdata     (bus_wdata),
                .cfg_idx   (cfg_idx),
                .code_clr  (clr_here),
                .code_idx  (rd_code[LINE_W-1:0]),
                .pend      (pend_b[b]),
                .mask      (mask_b[b]),
                .fiq_sel   (fiq_b),
                .prio_flat (prio_all[b*LINES*PRIO_W +: LINES*PRIO_W]),
                .cfg_rd    (cfg_b[b])
            );

            assign cand_k[0][b*LINES +: LINES] = pend_b[b] & ~mask_b[b] & ~fiq_b;
            assign cand_k[1][b*LINES +: LINES] = pend_b[b] & ~mask_b[b] & fiq_b;
        end
    endgenerate

    // Arbitration and grant, index 0 = normal, 1 = fast
    assign ack_k[0] = bus_wr && sel == REG_CTRL && bus_wdata[0];
    assign ack_k[1] = bus_wr && sel == REG_CTRL && bus_wdata[1];

    generate
        for (genvar k = 0; k < 2; k++) begin : g_grant
            icu_winner_pick #(
                .N_LINES (N_LINES),
                .CODE_W  (CODE_W)
            ) u_pick (
                .cand      (cand_k[k]),
                .prio_flat (prio_all),
                .any       (any_k[k]),
                .code      (win_k[k])
            );

            icu_grant_fsm #(
                .CODE_W (CODE_W)
            ) u_fsm (
                .clk    (clk),
                .rst_n  (rst_n),
                .any    (any_k[k]),
                .win    (win_k[k]),
                .ack    (ack_k[k]),
                .grant  (out_k[k]),
                .code_q (code_k[k])
            );
        end
    endgenerate

    assign cand_irq   = cand_k[0];
    assign cand_fiq   = cand_k[1];
    assign code_irq_q = code_k[0];
    assign code_fiq_q = code_k[1];
    assign irq_out    = out_k[0];
    assign fiq_out    = out_k[1];

    // Read mux
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            REG_PEND:     bus_rdata = pend_b[bsel];
            REG_MASK:     bus_rdata = mask_b[bsel];
            REG_CODE_IRQ: bus_rdata = DATA_W'(code_irq_q);
            REG_CODE_FIQ: bus_rdata = DATA_W'(code_fiq_q);
            REG_LCFG:     bus_rdata = DATA_W'(cfg_b[bsel]);
            REG_CTRL,
            REG_SWSET,
            REG_NONE:     bus_rdata = '0;
            default:      bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/icu_banked_checker.sv
`timescale 1ns/1ps
module icu_banked_checker #(
    parameter int N_LINES = 64,
    parameter int CODE_W  = 6,
    parameter int ADDR_W  = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [1:0]         ack_bits,
    input logic               irq_out,
    input logic               fiq_out,
    input logic [N_LINES-1:0] cand_irq,
    input logic [N_LINES-1:0] cand_fiq,
    input logic [CODE_W-1:0]  code_irq_q,
    input logic [CODE_W-1:0]  code_fiq_q
);

    logic ctrl_hit;
    assign ctrl_hit = bus_wr && (bus_addr == ADDR_W'(8'h18));

    assert_ack_drop_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hit && ack_bits[0]) |=> !irq_out);

    assert_ack_drop_fiq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hit && ack_bits[1]) |=> !fiq_out);

    assert_irq_code_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && $past(irq_out)) |-> (code_irq_q == $past(code_irq_q)));

    assert_fiq_code_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_out && $past(fiq_out)) |-> (code_fiq_q == $past(code_fiq_q)));

    assert_irq_winner_cand_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> (($past(cand_irq) & (N_LINES'(1) << code_irq_q)) != '0));

    assert_fiq_winner_cand_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fiq_out) |-> (($past(cand_fiq) & (N_LINES'(1) << code_fiq_q)) != '0));

endmodule

bind icu_banked_top icu_banked_checker #(
    .N_LINES (N_LINES),
    .CODE_W  (CODE_W),
    .ADDR_W  (ADDR_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .ack_bits   (bus_wdata[1:0]),
    .irq_out    (irq_out),
    .fiq_out    (fiq_out),
    .cand_irq   (cand_irq),
    .cand_fiq   (cand_fiq),
    .code_irq_q (code_irq_q),
    .code_fiq_q (code_fiq_q)
);

// File: tb/test_icu_banked_top.sv
`timescale 1ns/1ps
module test_icu_banked_top;

    localparam int NB = 2;
    localparam int NL = NB * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [8:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] req = '0;
    logic          irq_out;
    logic          fiq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    icu_banked_top #(.NUM_BANKS(NB)) i_icu_banked_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .req_in    (req),
        .irq_out   (irq_out),
        .fiq_out   (fiq_out)
    );

    // Behavioural reference model
    bit m_pend [NL];
    bit m_mask [NL];
    bit m_lvl  [NL];
    bit m_fiq  [NL];
    bit m_reqq [NL];
    int m_prio [NL];
    bit m_held [2];
    int m_code [2];

    task automatic model_reset();
        for (int i = 0; i < NL; i++) begin
            m_pend[i] = 0; m_mask[i] = 1; m_lvl[i] = 0;
            m_fiq[i] = 0; m_reqq[i] = 0; m_prio[i] = 0;
        end
        for (int k = 0; k < 2; k++) begin
            m_held[k] = 0; m_code[k] = 0;
        end
    endtask

    function automatic logic [31:0] model_read(logic [8:0] a);
        int o = int'(a[7:0]);
        int bk = int'(a[8]);
        logic [31:0] r = '0;
        if (o == 'h00) begin
            for (int j = 0; j < 32; j++) r[j] = m_pend[bk*32+j];
        end else if (o == 'h04) begin
            for (int j = 0; j < 32; j++) r[j] = m_mask[bk*32+j];
        end else if (o == 'h10 && bk == 0) begin
            r = m_code[0];
        end else if (o == 'h14 && bk == 0) begin
            r = m_code[1];
        end else if (o >= 'h1C && o <= 'h98 && o % 4 == 0) begin
            int ln = bk*32 + (o - 'h1C) / 4;
            r = (m_prio[ln] << 2) | (m_lvl[ln] << 1) | m_fiq[ln];
        end
        return r;
    endfunction

    task automatic model_edge();
        int o = int'(bus_addr[7:0]);
        int bk = int'(bus_addr[8]);
        bit nh [2];
        int nc [2];
        bit np [NL];
        int sw = -1;
        int cl = -1;
        for (int k = 0; k < 2; k++) begin
            bit any = 0;
            int best = 99;
            int w = 0;
            bit ack;
            for (int i = 0; i < NL; i++) begin
                if (m_pend[i] && !m_mask[i] && (int'(m_fiq[i]) == k) && m_prio[i] <= best) begin
                    best = m_prio[i]; w = i; any = 1;
                end
            end
            ack = bus_wr && bk == 0 && o == 'h18 && bus_wdata[k];
            nh[k] = m_held[k];
            nc[k] = m_code[k];
            if (ack) nh[k] = 0;
            else if (!m_held[k] && any) begin
                nh[k] = 1; nc[k] = w;
            end
        end
        if (bus_wr && o == 'h9C) begin
            for (int j = 31; j >= 0; j--) if (bus_wdata[j]) sw = bk*32 + j;
        end
        if (bus_rd && bk == 0 && (o == 'h10 || o == 'h14)) cl = m_code[(o - 'h10) / 4];
        for (int i = 0; i < NL; i++) begin
            bit s = 0;
            bit c = 0;
            if (!m_lvl[i] && req[i] && !m_reqq[i]) s = 1;
            if (m_lvl[i] && req[i]) s = 1;
            if (i == sw) s = 1;
            if (bus_wr && o == 'h00 && bk == i / 32 && !bus_wdata[i % 32]) c = 1;
            if (i == cl && !m_lvl[i]) c = 1;
            if (m_lvl[i] && !req[i] && m_reqq[i]) c = 1;
            np[i] = s ? 1'b1 : (c ? 1'b0 : m_pend[i]);
        end
        for (int i = 0; i < NL; i++) begin
            m_pend[i] = np[i];
            m_reqq[i] = req[i];
        end
        for (int k = 0; k < 2; k++) begin
            m_held[k] = nh[k]; m_code[k] = nc[k];
        end
        if (bus_wr && o == 'h04) begin
            for (int j = 0; j < 32; j++) m_mask[bk*32+j] = bus_wdata[j];
        end
        if (bus_wr && o >= 'h1C && o <= 'h98 && o % 4 == 0) begin
            int ln = bk*32 + (o - 'h1C) / 4;
            m_prio[ln] = int'(bus_wdata[6:2]);
            m_lvl[ln]  = bus_wdata[1];
            m_fiq[ln]  = bus_wdata[0];
        end
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R10 irq_out vs model", 32'(irq_out), 32'(m_held[0]));
        chk("R8 fiq_out vs model", 32'(fiq_out), 32'(m_held[1]));
    endtask

    task automatic wr(logic [8:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        cyc();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [8:0] a, logic [31:0] exp, string tag);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        chk(tag, bus_rdata, exp);
        chk({tag, " model"}, bus_rdata, model_read(a));
        cyc();
        bus_rd = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq low", 32'(irq_out), 0);
        chk("R1 fiq low", 32'(fiq_out), 0);
        rd(9'h004, 32'hFFFF_FFFF, "R1 mask bank0");
        rd(9'h104, 32'hFFFF_FFFF, "R1 mask bank1");
        rd(9'h000, 32'h0, "R1 pending");
        rd(9'h01C, 32'h0, "R1 line cfg");
        rd(9'h010, 32'h0, "R1 irq code");

        // R3 edge capture, R9 code, R12 read clear
        wr(9'h028, 32'h10);
        wr(9'h004, 32'hFFFF_FFF7);
        req[3] = 1'b1;
        cyc();
        rd(9'h000, 32'h8, "R3 edge pending");
        chk("R10 irq raised", 32'(irq_out), 1);
        rd(9'h010, 32'd3, "R9 code line 3");
        rd(9'h000, 32'h0, "R12 edge cleared by code read");
        wr(9'h018, 32'h1);
        cyc(); cyc();
        chk("R3 held input no retrigger", 32'(irq_out), 0);
        req[3] = 1'b0;
        cyc();

        // R9 priority and tie order across banks
        wr(9'h030, 32'h08);
        wr(9'h040, 32'h04);
        wr(9'h13C, 32'h04);
        rd(9'h13C, 32'h04, "R7 bank1 cfg readback");
        wr(9'h004, 32'h0);
        wr(9'h104, 32'h0);
        req[5] = 1'b1; req[9] = 1'b1; req[40] = 1'b1;
        cyc(); cyc();
        rd(9'h010, 32'd40, "R9 tie goes to higher line");
        wr(9'h018, 32'h1);
        cyc();
        rd(9'h010, 32'd9, "R9 best priority next");
        wr(9'h018, 32'h1);
        cyc();
        rd(9'h010, 32'd5, "R9 last winner");
        wr(9'h018, 32'h1);
        req[5] = 1'b0; req[9] = 1'b0; req[40] = 1'b0;
        cyc();

        // R8 fast routing, R11 ack and control readback
        wr(9'h038, 32'h01);
        rd(9'h038, 32'h01, "R7 routing bit readback");
        req[7] = 1'b1;
        cyc(); cyc();
        chk("R8 fiq raised", 32'(fiq_out), 1);
        chk("R8 irq stays low", 32'(irq_out), 0);
        rd(9'h014, 32'd7, "R8 fast code");
        wr(9'h018, 32'h2);
        chk("R11 fiq dropped", 32'(fiq_out), 0);
        rd(9'h018, 32'h0, "R11 control reads zero");
        req[7] = 1'b0;
        cyc();

        // R4 level capture, R12 level not cleared by read
        wr(9'h04C, 32'h0E);
        rd(9'h04C, 32'h0E, "R7 level cfg readback");
        req[12] = 1'b1;
        cyc(); cyc();
        rd(9'h010, 32'd12, "R9 level code");
        rd(9'h000, 32'h1000, "R12 level survives code read");
        wr(9'h000, 32'h0);
        rd(9'h000, 32'h1000, "R4 clear blocked while input high");
        req[12] = 1'b0;
        cyc();
        rd(9'h000, 32'h0, "R4 falling input clears");
        wr(9'h018, 32'h1);
        cyc();

        // R13 software set, R5 pending write, R6 mask
        wr(9'h004, 32'hFFFF_FFFF);
        wr(9'h09C, 32'h0000_0C00);
        rd(9'h000, 32'h0000_0400, "R13 lowest bit only");
        rd(9'h09C, 32'h0, "R13 reads zero");
        wr(9'h09C, 32'h8000_0000);
        wr(9'h000, 32'hFFFF_FBFF);
        rd(9'h000, 32'h8000_0000, "R5 and-write clears one bit");
        cyc(); cyc();
        chk("R6 masked stays low", 32'(irq_out), 0);
        wr(9'h004, 32'h7FFF_FFFF);
        cyc();
        chk("R6 unmask raises", 32'(irq_out), 1);
        rd(9'h010, 32'd31, "R6 unmasked winner");

        // R2 unmapped and bank-0-only offsets
        rd(9'h008, 32'h0, "R2 unmapped reads zero");
        wr(9'h008, 32'hFFFF_FFFF);
        rd(9'h008, 32'h0, "R2 write ignored");
        rd(9'h110, 32'h0, "R2 bank1 code offset");
        wr(9'h118, 32'h3);
        cyc();
        chk("R2 bank1 control ignored", 32'(irq_out), 1);
        wr(9'h018, 32'h1);
        chk("R11 irq dropped", 32'(irq_out), 0);
        cyc(); cyc();

        done = 1;
        summary();
        $finish;
    end

endmodule